// File: doc/BRIEF.md
# One-Wire Bus Master Slot Engine

This block is the bit-level master for a single open-drain one-wire bus. It is timed from a system clock that is a whole number of cycles per microsecond, 10 MHz by default. A one-cycle command strobe starts one of three operations:

- a reset pulse followed by presence detection;
- a write slot that carries a 0 or a 1;
- a read slot.

The engine pulls the bus low only through an output-enable and otherwise leaves it released. It samples a two-flop synchronized copy of the line, and at the end of each operation it gives a one-cycle done pulse. The presence flag or the read bit is updated together with that pulse.

A higher-level sequencer issues commands one at a time. It may wait for done, or it may watch busy. A strobe that arrives while an operation is running is dropped. Every slot ends with the line released for at least one microsecond, so a new command can follow straight after done.

Top module: `ow_slot_master`

## Requirements
- R1: After synchronous reset, line_oe, busy, done, presence and rd_bit are all 0.
- R2: Command code 0 (reset) drives line_oe high for exactly 480 us (4800 clocks at 10 MHz), counted from the clock edge that accepts the strobe. The done pulse follows 960 us after that edge, busy is high for the whole operation, and done lasts one cycle.
- R3: After a reset command, presence is 1 if the synchronized line was low 70 us after the pulse was released (550 us into the operation), and 0 otherwise. The new value appears with done.
- R4: Command code 1 (write) with cmd_bit=0 drives line_oe for 60 us, and done follows 70 us after the accepting edge.
- R5: Command code 1 with cmd_bit=1 drives line_oe for 6 us, and done follows 70 us after the accepting edge.
- R6: Command code 2 (read) drives line_oe for 1 us and samples the synchronized line 13 us into the slot. rd_bit takes that level (low gives 0) together with done, 70 us after the accepting edge.
- R7: line_oe is 0 in the cycle before done and in the done cycle. A command strobed in the done cycle is accepted at the next edge.
- R8: A strobe that arrives while busy is 1 is ignored: the running operation keeps its timing, and presence and rd_bit are not disturbed.
- R9: Command code 3 is ignored: busy, line_oe and done stay 0.
- R10: A write changes neither presence nor rd_bit, a reset leaves rd_bit unchanged, and a read leaves presence unchanged. Outside a done cycle neither output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | 0 reset, 1 write, 2 read, 3 no operation |
| cmd_bit | input | 1 | Bit value for a write command |
| line_in | input | 1 | Raw bus level (asynchronous) |
| line_oe | output | 1 | 1 pulls the bus low, 0 releases it |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| presence | output | 1 | A slave answered the last reset |
| rd_bit | output | 1 | Bit captured by the last read slot |

## Verification
The hardest cases to reach are those where the slave's low window sits near the sample point. One is a presence pulse that ends before the 70 us sample. The other is a read-0 response released before the 13 us sample. The bench models the slave as a low window placed in microseconds relative to the accepting edge and drives the line as the wired-AND of that window and line_oe. This lets each table row put the response just before, across or after the sample point. A second awkward case is a strobe landing in the middle of a running slot. The run task can inject one at a chosen cycle and then confirm that the slot's length and the result flags are unchanged.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    OW_RESET = 2'd0,
    OW_WRITE = 2'd1,
    OW_READ  = 2'd2,
    OW_NOP   = 2'd3
  } ow_op_e;
endpackage

// File: rtl/ow_sync.sv
// Multi-stage synchronizer for the raw bus level; idles high (released bus).
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ow_us_timer.sv
// Microsecond time base: a sub-cycle prescaler plus a microsecond counter.
module ow_us_timer #(
  parameter int CLK_PER_US = 10,
  parameter int US_W       = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            run,
  output logic            tick,
  output logic [US_W-1:0] us_cnt
);
  localparam int SUB_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLK_PER_US - 1);

  logic [SUB_W-1:0] sub_q;
  logic [US_W-1:0]  us_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sub_q <= '0;
      us_q  <= '0;
    end else if (run) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        us_q  <= us_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign tick   = run && !clear && (sub_q == SUB_LAST);
  assign us_cnt = us_q;
endmodule

// File: rtl/ow_slot_fsm.sv
// Operation sequencer: picks the windows for the accepted command and
// drives the output-enable, sample capture and result registers.
module ow_slot_fsm
  import ow_pkg::*;
#(
  parameter int US_W        = 10,
  parameter int RST_LOW_US  = 480,
  parameter int PRES_DLY_US = 70,
  parameter int RST_TOT_US  = 960,
  parameter int W0_LOW_US   = 60,
  parameter int W1_LOW_US   = 6,
  parameter int RD_LOW_US   = 1,
  parameter int RD_SAMP_US  = 13,
  parameter int SLOT_US     = 70
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic            cmd_bit,
  input  logic            line_s,
  input  logic            tick,
  input  logic [US_W-1:0] us_cnt,
  output logic            clear,
  output logic            busy,
  output logic            line_oe,
  output logic            done,
  output logic            presence,
  output logic            rd_bit
);
  localparam logic [US_W-1:0] L_RST_LOW = US_W'(RST_LOW_US);
  localparam logic [US_W-1:0] L_RST_SMP = US_W'(RST_LOW_US + PRES_DLY_US);
  localparam logic [US_W-1:0] L_RST_TOT = US_W'(RST_TOT_US);
  localparam logic [US_W-1:0] L_W0_LOW  = US_W'(W0_LOW_US);
  localparam logic [US_W-1:0] L_W1_LOW  = US_W'(W1_LOW_US);
  localparam logic [US_W-1:0] L_RD_LOW  = US_W'(RD_LOW_US);
  localparam logic [US_W-1:0] L_RD_SMP  = US_W'(RD_SAMP_US);
  localparam logic [US_W-1:0] L_SLOT    = US_W'(SLOT_US);

  ow_op_e          op_q;
  logic            bit_q;
  logic            busy_q;
  logic            oe_q;
  logic            done_q;
  logic            cap_q;
  logic            pres_q;
  logic            rdb_q;
  logic            start;
  logic [US_W-1:0] low_len;
  logic [US_W-1:0] samp_at;
  logic [US_W-1:0] total_at;
  logic [US_W-1:0] us_nxt;

  assign start  = cmd_valid && !busy_q && (ow_op_e'(cmd_op) != OW_NOP);
  assign clear  = start;
  assign us_nxt = us_cnt + 1'b1;

  // Window table for the operation in flight. A sample point of 0 is never
  // reached, because the count seen at a tick is at least 1.
  always_comb begin
    low_len  = L_RD_LOW;
    samp_at  = '0;
    total_at = L_SLOT;
    case (op_q)
      OW_RESET: begin
        low_len  = L_RST_LOW;
        samp_at  = L_RST_SMP;
        total_at = L_RST_TOT;
      end
      OW_WRITE: begin
        low_len  = bit_q ? L_W1_LOW : L_W0_LOW;
      end
      OW_READ: begin
        low_len  = L_RD_LOW;
        samp_at  = L_RD_SMP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OW_NOP;
      bit_q  <= 1'b0;
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      cap_q  <= 1'b1;
      pres_q <= 1'b0;
      rdb_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        op_q   <= ow_op_e'(cmd_op);
        bit_q  <= cmd_bit;
        busy_q <= 1'b1;
        oe_q   <= 1'b1;
        cap_q  <= 1'b1;
      end else if (busy_q && tick) begin
        oe_q <= (us_nxt < low_len);
        if (us_nxt == samp_at) cap_q <= line_s;
        if (us_nxt == total_at) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          oe_q   <= 1'b0;
          if (op_q == OW_RESET) pres_q <= ~cap_q;
          if (op_q == OW_READ)  rdb_q  <= cap_q;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign line_oe  = oe_q;
  assign done     = done_q;
  assign presence = pres_q;
  assign rd_bit   = rdb_q;
endmodule

// File: rtl/ow_slot_master.sv
module ow_slot_master #(
  parameter int CLK_PER_US  = 10,
  parameter int SYNC_STAGES = 2,
  parameter int RST_LOW_US  = 480,
  parameter int PRES_DLY_US = 70,
  parameter int RST_TOT_US  = 960,
  parameter int W0_LOW_US   = 60,
  parameter int W1_LOW_US   = 6,
  parameter int RD_LOW_US   = 1,
  parameter int RD_SAMP_US  = 13,
  parameter int SLOT_US     = 70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  input  logic       line_in,
  output logic       line_oe,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rd_bit
);
  localparam int MAX_US = (RST_TOT_US > SLOT_US) ? RST_TOT_US : SLOT_US;
  localparam int US_W   = $clog2(MAX_US + 2);

  logic            line_s;
  logic            tick;
  logic            clear;
  logic [US_W-1:0] us_cnt;

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_s)
  );

  ow_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear),
    .run    (busy),
    .tick   (tick),
    .us_cnt (us_cnt)
  );

  ow_slot_fsm #(
    .US_W        (US_W),
    .RST_LOW_US  (RST_LOW_US),
    .PRES_DLY_US (PRES_DLY_US),
    .RST_TOT_US  (RST_TOT_US),
    .W0_LOW_US   (W0_LOW_US),
    .W1_LOW_US   (W1_LOW_US),
    .RD_LOW_US   (RD_LOW_US),
    .RD_SAMP_US  (RD_SAMP_US),
    .SLOT_US     (SLOT_US)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bit   (cmd_bit),
    .line_s    (line_s),
    .tick      (tick),
    .us_cnt    (us_cnt),
    .clear     (clear),
    .busy      (busy),
    .line_oe   (line_oe),
    .done      (done),
    .presence  (presence),
    .rd_bit    (rd_bit)
  );
endmodule

// File: rtl/ow_slot_master_chk.sv
module ow_slot_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       line_oe,
  input logic       busy,
  input logic       done,
  input logic       presence,
  input logic       rd_bit
);
  AST_OE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> busy);                                              // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                // R2
  AST_DONE_ENDS_OP: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));                               // R2
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> (!line_oe && !$past(line_oe)));                        // R7
  AST_START_VALID_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(cmd_valid) && ($past(cmd_op) != 2'd3))); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(presence) && $stable(rd_bit)));              // R10
endmodule

bind ow_slot_master ow_slot_master_chk u_chk (.*);

// File: tb/sim_ow_slot_master.sv
module sim_ow_slot_master;
  localparam time CLK_PERIOD = 100ns;
  localparam int  CPU        = 10;

  typedef struct packed {
    logic [1:0]  op;
    logic        wbit;
    logic [15:0] sa;     // slave low window start, us after accept
    logic [15:0] sb;     // slave low window end, us
    logic [15:0] low;    // expected line_oe length, us
    logic [15:0] tot;    // expected done time, us
    logic        upd_p;
    logic        pres;
    logic        upd_r;
    logic        rdb;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TAB [NV] = '{
    '{2'd0, 1'b0, 16'd510, 16'd630, 16'd480, 16'd960, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd2, 1'b0, 16'd0,   16'd30,  16'd1,   16'd70,  1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd1, 1'b0, 16'd0,   16'd0,   16'd60,  16'd70,  1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b0, 16'd0,   16'd10,  16'd1,   16'd70,  1'b0, 1'b0, 1'b1, 1'b1},
    '{2'd1, 1'b1, 16'd0,   16'd0,   16'd6,   16'd70,  1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b0, 16'd490, 16'd540, 16'd480, 16'd960, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b0, 16'd510, 16'd630, 16'd480, 16'd960, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd2, 1'b0, 16'd0,   16'd30,  16'd1,   16'd70,  1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b0, 16'd0,   16'd0,   16'd480, 16'd960, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic       cmd_bit = 1'b0;
  logic       slave_low = 1'b0;
  logic       line_in;
  logic       line_oe, busy, done, presence, rd_bit;

  int n_chk = 0;
  int n_err = 0;
  logic exp_p = 1'b0;
  logic exp_r = 1'b0;

  assign line_in = !(line_oe || slave_low);

  always #(CLK_PERIOD / 2) clk = ~clk;

  ow_slot_master u0 (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .cmd_bit (cmd_bit), .line_in (line_in), .line_oe (line_oe),
    .busy (busy), .done (done), .presence (presence), .rd_bit (rd_bit)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs one command starting at a negedge; returns counts measured from the
  // accepting edge. inj >= 0 injects a read strobe at that cycle.
  task automatic run_op(input logic [1:0] op, input logic wb, input int sa, input int sb,
                        input int inj, output int oe_cnt, output int done_k, output logic oe_last);
    int k;
    logic prev_oe;
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = wb;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 0; oe_cnt = 0; prev_oe = 1'b1; oe_last = 1'b1; done_k = -1;
    slave_low = (sa * CPU <= 0) && (sb * CPU > 0);
    forever begin
      if (line_oe) oe_cnt++;
      if (done) begin
        done_k = k; oe_last = prev_oe;
        break;
      end
      prev_oe = line_oe;
      @(negedge clk);
      k++;
      slave_low = (k >= sa * CPU) && (k < sb * CPU);
      if (k == inj) begin cmd_valid = 1'b1; cmd_op = 2'd2; end
      else if (inj >= 0 && k == inj + 1) cmd_valid = 1'b0;
      if (k > 12000) begin
        n_chk++; n_err++;
        $display("FAIL R2 watchdog: no done actual=%0d expected=done", k);
        break;
      end
    end
    slave_low = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL R2 global watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int oc, dk;
    logic ol;
    string rq;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "line_oe", line_oe, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "presence", presence, 0);
    chk("R1", "rd_bit", rd_bit, 0);

    for (int i = 0; i < NV; i++) begin
      run_op(TAB[i].op, TAB[i].wbit, int'(TAB[i].sa), int'(TAB[i].sb), -1, oc, dk, ol);
      if (TAB[i].op == 2'd0) rq = "R2";
      else if (TAB[i].op == 2'd2) rq = "R6";
      else if (TAB[i].wbit) rq = "R5";
      else rq = "R4";
      chk(rq, "low cycles", oc, int'(TAB[i].low) * CPU);
      chk(rq, "done cycle", dk, int'(TAB[i].tot) * CPU);
      chk("R7", "oe before done", int'(ol), 0);
      if (TAB[i].upd_p) exp_p = TAB[i].pres;
      if (TAB[i].upd_r) exp_r = TAB[i].rdb;
      chk(TAB[i].upd_p ? "R3" : "R10", "presence", presence, exp_p);
      chk(TAB[i].upd_r ? "R6" : "R10", "rd_bit", rd_bit, exp_r);
    end

    // R7 back-to-back: strobe in the done cycle of the previous slot
    run_op(2'd1, 1'b1, 0, 0, -1, oc, dk, ol);
    run_op(2'd1, 1'b0, 0, 0, -1, oc, dk, ol);
    chk("R7", "b2b low cycles", oc, 60 * CPU);
    chk("R7", "b2b done cycle", dk, 70 * CPU);

    // R8 strobe while busy: read injected 30 us into a write-0 slot
    run_op(2'd1, 1'b0, 0, 0, 300, oc, dk, ol);
    chk("R8", "low cycles", oc, 60 * CPU);
    chk("R8", "done cycle", dk, 70 * CPU);
    chk("R8", "rd_bit", rd_bit, exp_r);
    chk("R8", "presence", presence, exp_p);
    @(negedge clk);
    chk("R8", "idle after", busy, 0);

    // R9 code 3 ignored
    cmd_valid = 1'b1; cmd_op = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int j = 0; j < 30; j++) begin
        if (busy || line_oe || done) seen++;
        @(negedge clk);
      end
      chk("R9", "activity cycles", seen, 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule